// File: doc/BRIEF.md
# Multi-depth pixel byte serializer

The serializer turns one screen byte into a run of colour pixels for a raster display. A byte arrives with a one-cycle valid strobe, together with a depth code that sets how many bits form one pixel and a scale code that sets how many output clocks each pixel is held for. The block then drives 3-bit RGB for each pixel in turn and raises a busy flag until the last pixel of the byte has been shown.

Multi-bit pixels do not come from adjacent bits. At two bits per pixel the two bits of a pixel sit four places apart in the byte. At four bits per pixel the four bits sit two places apart. The logical colour is reduced modulo 8 and goes straight onto the RGB lines. A blank request forces black and freezes the pixel position, so the display can insert spacing lines and then resume.

The fetch logic upstream raises the strobe at the start of its access slot once the byte is ready. The serializer accepts the byte only when it is idle or showing the final clock of its last pixel. Accepting on that final clock lets consecutive bytes run with no black gap between them.

Top module: `pixel_byte_serializer`

## Requirements
- R1: After reset, `busy` is 0 and `rgb` is 0.
- R2: With depth code 0 (1 bit per pixel), the byte gives 8 pixels. Pixel i is byte bit 7−i, so bit 7 is shown first.
- R3: With depth code 1 (2 bits per pixel), the byte gives 4 pixels. Pixel i has colour bit 1 = byte bit 7−i and colour bit 0 = byte bit 3−i.
- R4: With depth code 2 or 3 (4 bits per pixel), the byte gives 2 pixels. Pixel i has the 4-bit colour {byte bit 7−i, 5−i, 3−i, 1−i}, most significant bit first, and this colour is taken modulo 8.
- R5: Once the last pixel of a byte has been held for its full time, and no new byte is accepted, `busy` falls to 0 on the next clock.
- R6: Each pixel is held for 1, 2 or 4 clocks for scale codes 0, 1 and 2 or 3 respectively.
- R7: `rgb` carries the logical colour modulo 8: red on bit 0, green on bit 1 and blue on bit 2.
- R8: While `blank_req` is 1, `rgb` is 0 and the pixel position and hold count do not advance. They resume where they stopped once `blank_req` drops.
- R9: A strobe that arrives while busy, other than on the final clock of the last pixel, is ignored. The byte, depth and scale in use stay unchanged.
- R10: A strobe on the final clock of the last pixel loads the new byte. Its first pixel appears on the very next clock, with no black cycle in between.
- R11: Depth and scale are captured when the byte is loaded. Changing `depth_sel` or `scale_sel` later has no effect on that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_valid | input | 1 | Strobe: `load_byte` holds a fetched byte |
| load_byte | input | 8 | Screen byte to serialize |
| depth_sel | input | 2 | 0: 1 bpp, 1: 2 bpp, 2 or 3: 4 bpp |
| scale_sel | input | 2 | 0: hold 1 clock, 1: hold 2 clocks, 2 or 3: hold 4 clocks |
| blank_req | input | 1 | Force black and pause the serializer |
| rgb | output | 3 | Pixel colour: bit 0 red, bit 1 green, bit 2 blue |
| busy | output | 1 | A byte is being shown |

## Verification
The assertions check on every cycle that the following hold:
- the hold count and pixel index stay inside the limits set by the latched scale and depth;
- a blank cycle leaves the shift state untouched;
- a strobe during a byte changes neither depth nor scale;
- the flag drops, or the next byte starts at pixel zero, right after the final clock.

The bit interleaving of each depth and the exact colour sequence are shown only by the bench's scenarios, which compare every output cycle against colours computed from the bit rules. The same applies to the hold length, the gapless hand-over between bytes and the resume point after a blank.

// File: rtl/pixel_byte_serializer.sv
module pixel_byte_serializer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_valid,
  input  logic [7:0] load_byte,
  input  logic [1:0] depth_sel,
  input  logic [1:0] scale_sel,
  input  logic       blank_req,
  output logic [2:0] rgb,
  output logic       busy
);

  logic [7:0] shreg;
  logic [1:0] dep_q;
  logic [2:0] scl_q;
  logic [2:0] rep_q;
  logic [2:0] pix_q;
  logic [3:0] npix;
  logic       hold_done;
  logic       last_px;
  logic       take;
  logic [2:0] colour;

  assign npix      = (dep_q == 2'd0) ? 4'd8 : (dep_q == 2'd1) ? 4'd4 : 4'd2;
  assign hold_done = (rep_q == scl_q - 3'd1);
  assign last_px   = busy && !blank_req && hold_done && ({1'b0, pix_q} == npix - 4'd1);
  assign take      = load_valid && (!busy || last_px);

  always_comb begin
    case (dep_q)
      2'd0:    colour = {2'b00, shreg[7]};
      2'd1:    colour = {1'b0, shreg[7], shreg[3]};
      default: colour = {shreg[5], shreg[3], shreg[1]};
    endcase
  end

  assign rgb = (busy && !blank_req) ? colour : 3'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      dep_q <= '0;
      scl_q <= 3'd1;
      rep_q <= '0;
      pix_q <= '0;
      busy  <= 1'b0;
    end else if (take) begin
      shreg <= load_byte;
      dep_q <= (depth_sel == 2'd3) ? 2'd2 : depth_sel;
      scl_q <= (scale_sel == 2'd0) ? 3'd1 : (scale_sel == 2'd1) ? 3'd2 : 3'd4;
      rep_q <= '0;
      pix_q <= '0;
      busy  <= 1'b1;
    end else if (last_px) begin
      busy  <= 1'b0;
    end else if (busy && !blank_req) begin
      if (hold_done) begin
        rep_q <= '0;
        pix_q <= pix_q + 3'd1;
        shreg <= {shreg[6:0], 1'b0};
      end else begin
        rep_q <= rep_q + 3'd1;
      end
    end
  end

  assert_rep_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rep_q < scl_q));

  assert_pix_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, pix_q} < npix));

  assert_blank_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && blank_req) |=> ($stable(shreg) && $stable(pix_q) && $stable(rep_q) && busy));

  assert_midbyte_load_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_px && load_valid) |=> (busy && $stable(dep_q) && $stable(scl_q)));

  assert_idle_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_px && !load_valid) |=> !busy);

  assert_seamless_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (last_px && load_valid) |=> (busy && pix_q == 3'd0 && rep_q == 3'd0));

  assert_black_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rgb == 3'd0));

endmodule

// File: tb/pixel_byte_serializer_tb.sv
module pixel_byte_serializer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_valid = 1'b0;
  logic [7:0] load_byte = '0;
  logic [1:0] depth_sel = '0;
  logic [1:0] scale_sel = '0;
  logic       blank_req = 1'b0;
  logic [2:0] rgb;
  logic       busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pixel_byte_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_byte(load_byte),
    .depth_sel(depth_sel), .scale_sel(scale_sel), .blank_req(blank_req),
    .rgb(rgb), .busy(busy)
  );

  // {byte, depth code, scale code}
  localparam logic [11:0] VEC [8] = '{
    {8'hA5, 2'd0, 2'd0}, {8'hC3, 2'd0, 2'd1}, {8'h96, 2'd1, 2'd0}, {8'h3C, 2'd1, 2'd2},
    {8'h5A, 2'd2, 2'd0}, {8'hF0, 2'd2, 2'd1}, {8'h69, 2'd3, 2'd3}, {8'hE7, 2'd1, 2'd3}
  };

  function automatic int exp_col(logic [7:0] b, int d, int i);
    int c;
    case (d)
      0: c = b[7-i];
      1: c = 2 * b[7-i] + b[3-i];
      default: c = 8 * b[7-i] + 4 * b[5-i] + 2 * b[3-i] + b[1-i];
    endcase
    return c % 8;
  endfunction

  function automatic int depth_of(logic [1:0] ds);
    return (ds == 2'd3) ? 2 : ds;
  endfunction

  function automatic int scale_of(logic [1:0] ss);
    return (ss == 2'd0) ? 1 : (ss == 2'd1) ? 2 : 4;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_byte(logic [7:0] b, logic [1:0] ds, logic [1:0] ss, string tag);
    int d = depth_of(ds);
    int s = scale_of(ss);
    int n = 8 >> d;
    load_valid = 1'b1; load_byte = b; depth_sel = ds; scale_sel = ss;
    cyc();
    load_valid = 1'b0;
    for (int i = 0; i < n; i++)
      for (int r = 0; r < s; r++) begin
        chk(tag, rgb, exp_col(b, d, i));
        chk({tag, " busy"}, busy, 1);
        cyc();
      end
    chk("R5 idle after byte", busy, 0);
    chk("R5 black after byte", rgb, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 rgb in reset", rgb, 0);
    cyc();
    rst_n = 1'b1;
    cyc();
    chk("R1 busy after reset", busy, 0);
    chk("R1 rgb after reset", rgb, 0);

    foreach (VEC[k])
      run_byte(VEC[k][11:4], VEC[k][3:2], VEC[k][1:0], "R2 R3 R4 R6 R7 decode");

    // R8: blank freezes position. 0xC0 at 1bpp: 1,1,0,0,0,0,0,0
    load_valid = 1'b1; load_byte = 8'hC0; depth_sel = 2'd0; scale_sel = 2'd0;
    cyc();
    load_valid = 1'b0;
    chk("R8 first pixel", rgb, 1);
    blank_req = 1'b1;
    cyc();
    chk("R8 black during blank", rgb, 0);
    chk("R8 busy during blank", busy, 1);
    blank_req = 1'b0;
    cyc();
    chk("R8 resumes at pixel 1", rgb, 1);
    cyc();
    chk("R8 pixel 2", rgb, 0);
    repeat (5) cyc();
    chk("R8 still busy at pixel 7", busy, 1);
    cyc();
    chk("R8 R5 idle after frozen byte", busy, 0);

    // R9, R11: strobe mid-byte ignored; depth change ignored. 0x96 at 2bpp
    load_valid = 1'b1; load_byte = 8'h96; depth_sel = 2'd1; scale_sel = 2'd0;
    cyc();
    load_byte = 8'hFF; depth_sel = 2'd0; scale_sel = 2'd2;
    chk("R9 pixel 0", rgb, exp_col(8'h96, 1, 0));
    cyc();
    load_valid = 1'b0;
    chk("R9 pixel 1 of original byte", rgb, exp_col(8'h96, 1, 1));
    cyc();
    chk("R11 pixel 2 keeps 2bpp", rgb, exp_col(8'h96, 1, 2));
    cyc();
    chk("R11 pixel 3 keeps scale 1", rgb, exp_col(8'h96, 1, 3));
    cyc();
    chk("R9 R11 idle after 4 pixels", busy, 0);

    // R10: seamless reload. 0x5A 4bpp scale 2, then 0xA5 1bpp scale 1
    load_valid = 1'b1; load_byte = 8'h5A; depth_sel = 2'd2; scale_sel = 2'd1;
    cyc();
    load_valid = 1'b0;
    chk("R10 A pixel 0", rgb, exp_col(8'h5A, 2, 0));
    cyc(); cyc();
    chk("R10 A pixel 1", rgb, exp_col(8'h5A, 2, 1));
    cyc();
    load_valid = 1'b1; load_byte = 8'hA5; depth_sel = 2'd0; scale_sel = 2'd0;
    chk("R10 A pixel 1 final clock", rgb, exp_col(8'h5A, 2, 1));
    cyc();
    load_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chk("R10 B pixel", rgb, exp_col(8'hA5, 0, i));
      chk("R10 busy no gap", busy, 1);
      cyc();
    end
    chk("R10 R5 idle after B", busy, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule